// File: doc/BRIEF.md
# Two-way set-associative write-back cache

This block sits between a processor port and a slower line-wide memory port. Each request names a word address. The address splits into three fields, from low to high: the word offset inside the line, the set index, and the tag. The set index picks one set. The two ways of that set compare their stored tags against the request tag at the same time. If a way is valid and its tag matches, the access completes inside the cache. Reads return the selected word. Writes merge the new word into the line and mark the line modified.

On a miss, the controller picks a victim. An invalid way is used first. If both ways are valid, the way touched least recently is evicted, and reads and writes both count as touches. A modified victim is first written to memory as a whole line, and then the missing line is fetched. A clean victim skips the write. After the fetch, the held processor request is replayed and now hits. Stores that miss therefore allocate the line and merge into it. Memory sees a modified line only when that line is evicted.

The processor holds `cpu_req` and its operands until it sees a one-cycle `cpu_ready`. The memory side holds `mem_req` with a stable address and direction until it sees a one-cycle `mem_ack`.

Top module: `cache2w_top`

## Requirements
- R1: A synchronous reset clears every valid, dirty and recency bit. In the cycle after reset, neither `cpu_ready` nor `mem_req` is high, and the first access to any address misses.
- R2: A request hits when a way of the selected set is valid and holds the request tag. At most one way matches. On a read hit, `cpu_rdata` is the word at offset k of that way's line, taken from bits k*WORD_W upward.
- R3: When both ways of a set are valid, a miss evicts the way accessed less recently. A read hit, a write hit and a completed fill all count as accesses.
- R4: If a way of the selected set is invalid, a miss fills it without any eviction. Way 0 is chosen when both ways are invalid.
- R5: A store changes only the cached line and marks it modified. The backing memory keeps its old value until that line is evicted.
- R6: A modified victim is written to memory before the refill: `mem_we`=1 with `mem_addr` = {victim tag, set, zero offset}, carrying the full line. The refill request (`mem_we`=0) follows directly after that write is acknowledged.
- R7: Evicting a clean line produces no memory write. The refill read is issued directly.
- R8: A store that misses first fetches the line from memory and then merges the store. The other words of that line keep their memory values.
- R9: With 2-word lines, 2 sets and a 4-bit address, the read trace 0, 1, 13, 8, 0 reports miss, hit, miss, miss, miss on `cpu_hit`.
- R10: `cpu_ready` is a single-cycle pulse, and `cpu_hit` tells whether the request hit on its first lookup. While `mem_req` is high and unacknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit on first lookup (valid with `cpu_ready`) |
| cpu_rdata | output | WORD_W | Load data (valid with `cpu_ready`) |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_addr | output | ADDR_W | Line-aligned word address |
| mem_wdata | output | WORD_W*LINE_WORDS | Line being written back |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rdata | input | WORD_W*LINE_WORDS | Fetched line, valid with `mem_ack` |

## Verification
The bench builds the cache with a 4-bit address, 2 sets, 2-word lines and 8-bit words. With this shape, three distinct lines are enough to fill a set and force an eviction, and the known five-address trace can be replayed exactly. A short sequence can therefore reach the cases that matter: clean evictions, dirty evictions, write-miss allocation, and a victim choice that depends on whether a write counted as a touch. A reference model of tags, recency and dirty state predicts both the hit flag of every access and the exact address of every writeback.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVICT,
      ST_REFILL,
      ST_DONE
   } cstate_t;
endpackage

// File: rtl/cache2w_way.sv
// One way of the cache: valid/dirty/tag/line storage for every set.
module cache2w_way #(
   parameter int SETS   = 16,
   parameter int SET_W  = 4,
   parameter int TAG_W  = 8,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SET_W-1:0]  set_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              wr_i,
   input  logic              wdirty_i,
   input  logic [LINE_W-1:0] wline_i,
   output logic              match_o,
   output logic              valid_o,
   output logic              dirty_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [LINE_W-1:0] line_o
);
   logic [SETS-1:0]   vld_q;
   logic [SETS-1:0]   drt_q;
   logic [TAG_W-1:0]  tag_q [SETS];
   logic [LINE_W-1:0] dat_q [SETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
         drt_q <= '0;
      end else if (wr_i) begin
         vld_q[set_i] <= 1'b1;
         drt_q[set_i] <= wdirty_i;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_i) begin
         tag_q[set_i] <= tag_i;
         dat_q[set_i] <= wline_i;
      end
   end

   assign valid_o = vld_q[set_i];
   assign dirty_o = drt_q[set_i];
   assign tag_o   = tag_q[set_i];
   assign line_o  = dat_q[set_i];
   assign match_o = vld_q[set_i] && (tag_q[set_i] == tag_i);
endmodule

// File: rtl/cache2w_lru.sv
// One recency bit per set naming the way to evict next, plus victim choice.
module cache2w_lru #(
   parameter int SETS  = 16,
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_i,
   input  logic             touch_i,
   input  logic             used_way_i,
   input  logic [1:0]       valid_i,
   output logic             victim_o
);
   logic [SETS-1:0] old_q;

   always_ff @(posedge clk) begin
      if (rst)          old_q <= '0;
      else if (touch_i) old_q[set_i] <= ~used_way_i;
   end

   always_comb begin
      if (!valid_i[0])      victim_o = 1'b0;
      else if (!valid_i[1]) victim_o = 1'b1;
      else                  victim_o = old_q[set_i];
   end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
   parameter int ADDR_W     = 16,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cpu_req,
   input  logic                         cpu_we,
   input  logic [ADDR_W-1:0]            cpu_addr,
   input  logic [WORD_W-1:0]            cpu_wdata,
   output logic                         cpu_ready,
   output logic                         cpu_hit,
   output logic [WORD_W-1:0]            cpu_rdata,
   output logic                         mem_req,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [WORD_W*LINE_WORDS-1:0] mem_wdata,
   input  logic                         mem_ack,
   input  logic [WORD_W*LINE_WORDS-1:0] mem_rdata
);
   import cache2w_pkg::*;

   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int LINE_W = WORD_W * LINE_WORDS;
   localparam int WAYS   = 2;

   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for SETS and LINE_WORDS");
   end

   cstate_t            state;
   logic [ADDR_W-1:0]  rq_addr;
   logic               vic_q;
   logic               missed;
   logic               hit_q;
   logic [WORD_W-1:0]  rdata_q;

   logic [ADDR_W-1:0]  cur_addr;
   logic [OFF_W-1:0]   cur_off;
   logic [SET_W-1:0]   cur_set;
   logic [TAG_W-1:0]   cur_tag;

   logic [WAYS-1:0]    w_match, w_valid, w_dirty, w_wr;
   logic [TAG_W-1:0]   w_tag  [WAYS];
   logic [LINE_W-1:0]  w_line [WAYS];
   logic [LINE_W-1:0]  w_wline [WAYS];

   logic               hit, hit_way, victim, touch, lookup;
   logic [LINE_W-1:0]  merged;

   assign cur_addr = (state == ST_IDLE) ? cpu_addr : rq_addr;
   assign cur_off  = cur_addr[OFF_W-1:0];
   assign cur_set  = cur_addr[OFF_W +: SET_W];
   assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];

   assign lookup  = (state == ST_IDLE) && cpu_req;
   assign hit     = |w_match;
   assign hit_way = w_match[1];
   assign touch   = lookup && hit;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign w_wr[w] = (touch && cpu_we && (hit_way == w[0]))
                    || ((state == ST_REFILL) && mem_ack && (vic_q == w[0]));
      assign w_wline[w] = (state == ST_REFILL) ? mem_rdata : merged;

      cache2w_way #(
         .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
      ) u_way (
         .clk(clk), .rst(rst),
         .set_i(cur_set), .tag_i(cur_tag),
         .wr_i(w_wr[w]), .wdirty_i(state != ST_REFILL), .wline_i(w_wline[w]),
         .match_o(w_match[w]), .valid_o(w_valid[w]), .dirty_o(w_dirty[w]),
         .tag_o(w_tag[w]), .line_o(w_line[w])
      );
   end

   cache2w_lru #(.SETS(SETS), .SET_W(SET_W)) u_lru (
      .clk(clk), .rst(rst), .set_i(cur_set),
      .touch_i(touch), .used_way_i(hit_way),
      .valid_i(w_valid), .victim_o(victim)
   );

   always_comb begin
      merged = w_line[hit_way];
      merged[cur_off*WORD_W +: WORD_W] = cpu_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         rq_addr <= '0;
         vic_q   <= 1'b0;
         missed  <= 1'b0;
         hit_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cpu_req) begin
               if (hit) begin
                  rdata_q <= w_line[hit_way][cur_off*WORD_W +: WORD_W];
                  hit_q   <= ~missed;
                  missed  <= 1'b0;
                  state   <= ST_DONE;
               end else begin
                  missed  <= 1'b1;
                  rq_addr <= cpu_addr;
                  vic_q   <= victim;
                  state   <= (w_valid[victim] && w_dirty[victim]) ? ST_EVICT : ST_REFILL;
               end
            end
            ST_EVICT:  if (mem_ack) state <= ST_REFILL;
            ST_REFILL: if (mem_ack) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready = (state == ST_DONE);
   assign cpu_hit   = hit_q;
   assign cpu_rdata = rdata_q;
   assign mem_req   = (state == ST_EVICT) || (state == ST_REFILL);
   assign mem_we    = (state == ST_EVICT);
   assign mem_addr  = (state == ST_EVICT) ? {w_tag[vic_q], cur_set, {OFF_W{1'b0}}}
                                          : {cur_tag, cur_set, {OFF_W{1'b0}}};
   assign mem_wdata = w_line[vic_q];

   // R1: nothing is active in the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!cpu_ready && !mem_req));
   // R2: the two ways of a set never both match
   p_onehot_hit_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(w_match));
   // R6: an acknowledged writeback is followed directly by the refill read
   p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
   // R7: a miss on a clean or empty victim goes straight to the refill read
   p_clean_skip_r7: assert property (@(posedge clk) disable iff (rst)
      (lookup && !hit && !(w_valid[victim] && w_dirty[victim])) |=> (mem_req && !mem_we));
   // R10: completion is a single-cycle pulse
   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |=> !cpu_ready);
   // R10: memory request stays stable until acknowledged
   p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
endmodule

// File: tb/cache2w_top_tb.sv
`timescale 1ns/1ps
module cache2w_top_tb;
   localparam int AW = 4;
   localparam int WW = 8;
   localparam int LW = 2;
   localparam int NS = 2;

   typedef struct {
      logic [AW-1:0] addr;
      logic          we;
      logic          hit;
      logic [WW-1:0] data;
      string         rq;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [WW-1:0] cpu_wdata = '0;
   logic cpu_ready, cpu_hit;
   logic [WW-1:0] cpu_rdata;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [WW*LW-1:0] mem_wdata;
   logic mem_ack = 1'b0;
   logic [WW*LW-1:0] mem_rdata = '0;

   int total = 0, bad = 0, wb_cnt = 0;
   item_t sb_q[$];
   logic [AW-1:0] wb_q[$];

   logic [WW-1:0] mem [16];
   logic [WW-1:0] gold [16];
   logic       rv [NS][2];
   logic       rd [NS][2];
   logic [1:0] rt [NS][2];
   logic       rl [NS];

   always #2.5 clk = ~clk;

   cache2w_top #(.ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LW), .SETS(NS)) u_dut (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   function automatic logic [WW-1:0] init_val(input int i);
      return 8'(i * 29 + 7);
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Reference model of the requirements: predicts hit flag, data and writebacks.
   task automatic access(input logic we, input logic [AW-1:0] a,
                         input logic [WW-1:0] d, input string rq);
      item_t it;
      int s, w;
      logic h;
      s = int'(a[1]);
      h = 1'b0;
      w = 0;
      for (int k = 0; k < 2; k++)
         if (rv[s][k] && rt[s][k] == a[3:2]) begin h = 1'b1; w = k; end
      if (!h) begin
         w = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : int'(rl[s]));
         if (rv[s][w] && rd[s][w]) wb_q.push_back({rt[s][w], a[1], 1'b0});
         rv[s][w] = 1'b1; rd[s][w] = 1'b0; rt[s][w] = a[3:2];
      end
      if (we) begin rd[s][w] = 1'b1; gold[a] = d; end
      rl[s] = (w == 0);
      it.addr = a; it.we = we; it.hit = h; it.data = gold[a]; it.rq = rq;
      sb_q.push_back(it);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      do @(negedge clk); while (!cpu_ready);
      cpu_req = 1'b0;
   endtask

   // Monitor: pops expected items as completions appear.
   initial forever begin
      @(negedge clk);
      if (cpu_ready) begin
         if (sb_q.size() == 0) chk(1'b0, "R10 unexpected ready", 1, 0);
         else begin
            item_t it;
            it = sb_q.pop_front();
            chk(cpu_hit == it.hit, {it.rq, " hit flag"}, int'(cpu_hit), int'(it.hit));
            if (!it.we)
               chk(cpu_rdata == it.data, {it.rq, " read data"}, int'(cpu_rdata), int'(it.data));
         end
      end
   end

   // Memory model: acknowledges a transfer on its third cycle of request.
   initial begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < 16; i++) mem[i] = init_val(i);
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_req) begin
            cnt++;
            if (cnt == 3) begin
               cnt = 0;
               mem_ack = 1'b1;
               if (mem_we) begin
                  wb_cnt++;
                  if (wb_q.size() == 0) chk(1'b0, "R7 unexpected writeback", int'(mem_addr), 0);
                  else begin
                     logic [AW-1:0] ea;
                     ea = wb_q.pop_front();
                     chk(mem_addr == ea, "R6 writeback address", int'(mem_addr), int'(ea));
                  end
                  mem[int'(mem_addr)]     = mem_wdata[WW-1:0];
                  mem[int'(mem_addr) + 1] = mem_wdata[2*WW-1:WW];
               end else begin
                  mem_rdata = {mem[int'(mem_addr) + 1], mem[int'(mem_addr)]};
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int wb0;
      for (int i = 0; i < 16; i++) gold[i] = init_val(i);
      for (int s = 0; s < NS; s++) begin
         rl[s] = 1'b0;
         for (int k = 0; k < 2; k++) begin rv[s][k] = 1'b0; rd[s][k] = 1'b0; rt[s][k] = '0; end
      end
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(cpu_ready == 1'b0, "R1 ready after reset", int'(cpu_ready), 0);
      chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);

      // R9 trace, also R2 hit and R3 recency victim choice
      access(1'b0, 4'd0,  8'h00, "R9 trace 0");
      access(1'b0, 4'd1,  8'h00, "R9 trace 1");
      access(1'b0, 4'd13, 8'h00, "R9 trace 13");
      access(1'b0, 4'd8,  8'h00, "R9 trace 8");
      access(1'b0, 4'd0,  8'h00, "R9 trace 0 again");

      // R5 store hit stays in cache
      access(1'b1, 4'd0, 8'h5A, "R5 store hit");
      chk(mem[0] == init_val(0), "R5 memory untouched", int'(mem[0]), int'(init_val(0)));
      access(1'b0, 4'd0, 8'h00, "R2 read back");

      // R7 clean victim: no write
      wb0 = wb_cnt;
      access(1'b0, 4'd13, 8'h00, "R7 clean eviction");
      chk(wb_cnt == wb0, "R7 writeback count", wb_cnt, wb0);

      // R6 dirty victim written back before refill
      access(1'b0, 4'd4, 8'h00, "R6 dirty eviction");
      chk(wb_cnt == wb0 + 1, "R6 writeback count", wb_cnt, wb0 + 1);
      chk(mem[0] == 8'h5A, "R6 memory updated", int'(mem[0]), 8'h5A);
      access(1'b0, 4'd0, 8'h00, "R6 refetch after writeback");

      // R8 write miss allocates
      access(1'b1, 4'd3, 8'hC3, "R8 write miss");
      access(1'b0, 4'd2, 8'h00, "R8 neighbour word from memory");
      access(1'b0, 4'd3, 8'h00, "R8 merged word");
      chk(mem[3] == init_val(3), "R5 memory untouched after allocate", int'(mem[3]), int'(init_val(3)));

      // R4 invalid way filled without eviction
      access(1'b1, 4'd7, 8'h77, "R4 fill empty way");
      access(1'b0, 4'd2, 8'h00, "R4 other way kept");

      // R3 a write counts as an access for recency
      access(1'b1, 4'd3, 8'h3C, "R3 write touch");
      access(1'b0, 4'd11, 8'h00, "R3 victim after write touch");
      chk(mem[7] == 8'h77, "R3 evicted line written", int'(mem[7]), 8'h77);
      access(1'b0, 4'd3, 8'h00, "R3 touched line kept");

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R10 all requests completed", sb_q.size(), 0);
      chk(wb_q.size() == 0, "R6 all expected writebacks seen", wb_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule